// File: doc/BRIEF.md
# SPI Output-Driver Diagnostic Sequencer

This block is a host-side SPI master that checks an eight-channel low-side output driver. A requester hands it a control byte, where a 0 bit turns a channel on and a 1 bit turns it off. The block writes the byte, keeps chip-select high for a settling interval, and then writes the same byte a second time. During the second write the driver shifts back one diagnostic bit per channel, which is the level seen on that output pin.

The block compares each returned bit with the bit that was written. A mismatch becomes either a short/overload flag or an open-load flag for that channel. The block builds chip-select, the serial clock and the data line itself, and it samples the driver's serial data. Every timing interval is a parameter counted in system clock cycles.

The request port uses valid/ready. `req_ready` is high only when the block is idle. A request is taken on the cycle where both `req_valid` and `req_ready` are high. While the block is busy it applies back-pressure by holding `req_ready` low. A requester that keeps `req_valid` high then keeps its byte until `req_ready` returns. The flags, `busy` and `done` are plain status signals.

Top module: `spi_drvdiag_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `busy` is 0. A request is taken when `req_valid` and `req_ready` are both 1. `busy` is 1 from the next cycle through the `done` cycle, then returns to 0. `req_ready` is 0 while `busy` is 1, so a request offered during that time is not taken and does not start a sequence.
- R2: Each sequence makes exactly two chip-select-low transfers of 8 bits each. Both carry the accepted byte, bit 7 first, so the driver ends up holding that byte.
- R3: `spi_sclk` rests low and is low in the cycle before and the cycle of every `spi_cs_n` change. It toggles only while `spi_cs_n` is low.
- R4: At least LEAD_CYC cycles pass from the fall of `spi_cs_n` to the first rise of `spi_sclk`. At least LAG_CYC cycles pass from the last fall of `spi_sclk` to the rise of `spi_cs_n`.
- R5: Every high phase of `spi_sclk` lasts exactly HALF_CYC cycles. Every low phase between two bits of one transfer also lasts exactly HALF_CYC cycles.
- R6: `spi_mosi` changes only on the cycle where `spi_sclk` rises. It stays constant through the high phase and across the falling edge, where the driver captures it.
- R7: Between the two transfers of a sequence, `spi_cs_n` stays high for at least SETTLE_CYC cycles.
- R8: `spi_miso` is sampled at the end of each high phase of `spi_sclk`. The first sample belongs to channel 7. Only samples from the second transfer are classified.
- R9: `short_flags[i]` is set when written bit i is 0 and returned bit i is 1.
- R10: `open_flags[i]` is set when written bit i is 1 and returned bit i is 0.
- R11: A channel whose returned bit equals its written bit has both flags clear. Both flag vectors reset to 0 and change only in a `done` cycle, then hold.
- R12: `done` is a single-cycle pulse. The new flags are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, can accept a request |
| req_byte | input | NBITS | Control byte, 0 = channel on |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| short_flags | output | NBITS | Per-channel short/overload result |
| open_flags | output | NBITS | Per-channel open-load result |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the driver |
| spi_miso | input | 1 | Diagnostic data from the driver |

## Verification
The assertions assume the interval parameters are at least 1. They also assume `spi_miso` holds steady from one rising edge of `spi_sclk` until the next falling edge, as a slave that shifts on the falling edge would. The bench meets this with a behavioural driver model. It loads pin levels when chip-select falls, shifts on falling clock edges and updates its latch when chip-select rises. Faults are injected as per-channel stuck-high and floating masks, so each returned bit follows from the written byte. Requests during a busy sequence are pulsed only while `req_ready` is low.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  typedef enum logic [2:0] {X_IDLE, X_LEAD, X_HIGH, X_LOW, X_LAG} xfer_st_t;
  typedef enum logic [2:0] {S_IDLE, S_WR1, S_SETTLE, S_WR2, S_FIN} seq_st_t;
endpackage

// File: rtl/sdd_xfer.sv
module sdd_xfer
  import sdd_pkg::*;
#(
  parameter int NBITS    = 8,
  parameter int HALF_CYC = 32,
  parameter int LEAD_CYC = 32,
  parameter int LAG_CYC  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NBITS-1:0] tx_byte,
  input  logic             miso,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  output logic [NBITS-1:0] rx_byte,
  output logic             xdone
);
  localparam int TMAX = (HALF_CYC > LEAD_CYC) ? ((HALF_CYC > LAG_CYC) ? HALF_CYC : LAG_CYC)
                                              : ((LEAD_CYC > LAG_CYC) ? LEAD_CYC : LAG_CYC);
  localparam int CW = $clog2(TMAX + 1);
  localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;

  xfer_st_t         st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bit_idx;
  logic [NBITS-1:0] txsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= X_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      txsh    <= '0;
      rx_byte <= '0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      xdone   <= 1'b0;
    end else begin
      xdone <= 1'b0;
      case (st)
        X_IDLE: if (start) begin
          txsh    <= tx_byte;
          cs_n    <= 1'b0;
          cnt     <= '0;
          bit_idx <= '0;
          st      <= X_LEAD;
        end
        X_LEAD, X_LOW: begin
          if (cnt == CW'(((st == X_LEAD) ? LEAD_CYC : HALF_CYC) - 1)) begin
            cnt  <= '0;
            sclk <= 1'b1;
            mosi <= txsh[NBITS-1];
            txsh <= txsh << 1;
            st   <= X_HIGH;
          end else cnt <= cnt + 1'b1;
        end
        X_HIGH: begin
          if (cnt == CW'(HALF_CYC - 1)) begin
            cnt     <= '0;
            sclk    <= 1'b0;
            rx_byte <= {rx_byte[NBITS-2:0], miso};
            bit_idx <= bit_idx + 1'b1;
            st      <= (bit_idx == BW'(NBITS - 1)) ? X_LAG : X_LOW;
          end else cnt <= cnt + 1'b1;
        end
        X_LAG: begin
          if (cnt == CW'(LAG_CYC - 1)) begin
            cnt   <= '0;
            cs_n  <= 1'b1;
            xdone <= 1'b1;
            st    <= X_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= X_IDLE;
      endcase
    end
  end

  logic [CW-1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= sclk ? hi_run + 1'b1 : '0;
  end

  p_cs_edge_clk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> (!sclk && !$past(sclk)));
  p_clk_only_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> (!cs_n && !$past(cs_n)));
  p_mosi_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sclk) |-> $stable(mosi));
  p_high_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_run == CW'(HALF_CYC)));
endmodule

// File: rtl/sdd_fault_cmp.sv
module sdd_fault_cmp #(
  parameter int NBITS = 8
) (
  input  logic [NBITS-1:0] wr_bits,
  input  logic [NBITS-1:0] rd_bits,
  output logic [NBITS-1:0] short_o,
  output logic [NBITS-1:0] open_o
);
  for (genvar i = 0; i < NBITS; i++) begin : g_ch
    assign short_o[i] = ~wr_bits[i] &  rd_bits[i];
    assign open_o[i]  =  wr_bits[i] & ~rd_bits[i];
  end
endmodule

// File: rtl/spi_drvdiag_seq.sv
module spi_drvdiag_seq
  import sdd_pkg::*;
#(
  parameter int NBITS      = 8,
  parameter int HALF_CYC   = 32,
  parameter int LEAD_CYC   = 32,
  parameter int LAG_CYC    = 32,
  parameter int SETTLE_CYC = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [NBITS-1:0] req_byte,
  output logic             busy,
  output logic             done,
  output logic [NBITS-1:0] short_flags,
  output logic [NBITS-1:0] open_flags,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  seq_st_t          st;
  logic [SW-1:0]    scnt;
  logic [NBITS-1:0] wr_byte;
  logic             xstart, xdone;
  logic [NBITS-1:0] rx_byte, cmp_short, cmp_open;

  assign req_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);

  sdd_xfer #(.NBITS(NBITS), .HALF_CYC(HALF_CYC), .LEAD_CYC(LEAD_CYC), .LAG_CYC(LAG_CYC)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(xstart), .tx_byte(wr_byte), .miso(spi_miso),
    .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi), .rx_byte(rx_byte), .xdone(xdone)
  );

  sdd_fault_cmp #(.NBITS(NBITS)) u_cmp (
    .wr_bits(wr_byte), .rd_bits(rx_byte), .short_o(cmp_short), .open_o(cmp_open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      scnt        <= '0;
      wr_byte     <= '0;
      xstart      <= 1'b0;
      short_flags <= '0;
      open_flags  <= '0;
    end else begin
      xstart <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wr_byte <= req_byte;
          xstart  <= 1'b1;
          st      <= S_WR1;
        end
        S_WR1: if (xdone) begin
          scnt <= '0;
          st   <= S_SETTLE;
        end
        S_SETTLE: begin
          if (scnt == SW'(SETTLE_CYC - 1)) begin
            xstart <= 1'b1;
            st     <= S_WR2;
          end else scnt <= scnt + 1'b1;
        end
        S_WR2: if (xdone) begin
          short_flags <= cmp_short;
          open_flags  <= cmp_open;
          st          <= S_FIN;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(short_flags) || !$stable(open_flags)) |-> done);
endmodule

// File: tb/sim_spi_drvdiag_seq.sv
module sim_spi_drvdiag_seq;
  localparam int HALF_P = 3, LEAD_P = 4, LAG_P = 5, SET_P = 40;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_byte = '0;
  logic req_ready, busy, done, spi_cs_n, spi_sclk, spi_mosi, spi_miso;
  logic [7:0] short_flags, open_flags;

  always #4 clk = ~clk;

  spi_drvdiag_seq #(.NBITS(8), .HALF_CYC(HALF_P), .LEAD_CYC(LEAD_P), .LAG_CYC(LAG_P),
                    .SETTLE_CYC(SET_P)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_byte(req_byte),
    .busy(busy), .done(done), .short_flags(short_flags), .open_flags(open_flags),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // Driver model: pin high when off and connected, or stuck high.
  logic [7:0] stuck_hi = '0, floating = '0;
  logic [7:0] s_sr = '0, s_latch = 8'hFF;
  logic s_pcs = 1'b1, s_psclk = 1'b0;
  assign spi_miso = spi_cs_n ? 1'b0 : s_sr[7];
  always @(spi_cs_n or spi_sclk) begin
    if (s_pcs === 1'b1 && spi_cs_n === 1'b0) s_sr = stuck_hi | (s_latch & ~floating);
    else if (s_psclk === 1'b1 && spi_sclk === 1'b0 && spi_cs_n === 1'b0) s_sr = {s_sr[6:0], spi_mosi};
    if (s_pcs === 1'b0 && spi_cs_n === 1'b1) s_latch = s_sr;
    s_pcs = spi_cs_n;
    s_psclk = spi_sclk;
  end

  // Timing monitor, sampled away from the active edge.
  logic pcs = 1'b1, psclk = 1'b0, pmosi = 1'b0, pbusy = 1'b0, rise_pend = 1'b0;
  int cnt_cs = 0, cnt_sclk = 0, fall_in_seq = 0;
  int bad_lead = 0, bad_lag = 0, bad_high = 0, bad_low = 0, bad_edge = 0;
  int bad_gate = 0, bad_mosi = 0, bad_settle = 0;
  always @(negedge clk) if (rst_n) begin
    if (busy && !pbusy) fall_in_seq = 0;
    if (spi_cs_n != pcs) begin
      if (spi_sclk || psclk) bad_edge++;
      if (!spi_cs_n) begin
        if (fall_in_seq == 1 && cnt_cs < SET_P) bad_settle++;
        fall_in_seq++;
        rise_pend = 1'b1;
      end else if (cnt_sclk < LAG_P) bad_lag++;
    end
    if (spi_sclk != psclk) begin
      if (spi_cs_n || pcs) bad_gate++;
      if (spi_sclk) begin
        if (rise_pend) begin
          if (cnt_cs < LEAD_P) bad_lead++;
          rise_pend = 1'b0;
        end else if (cnt_sclk != HALF_P) bad_low++;
      end else if (cnt_sclk != HALF_P) bad_high++;
    end
    if (psclk && spi_mosi != pmosi) bad_mosi++;
    cnt_cs   = (spi_cs_n != pcs) ? 1 : cnt_cs + 1;
    cnt_sclk = (spi_sclk != psclk) ? 1 : cnt_sclk + 1;
    pcs = spi_cs_n; psclk = spi_sclk; pmosi = spi_mosi; pbusy = busy;
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic run_seq(input logic [7:0] b, input logic [7:0] sh, input logic [7:0] op);
    logic [7:0] diag, es, eo;
    stuck_hi = sh; floating = op;
    diag = sh | (b & ~op);
    es = ~b & diag;
    eo = b & ~diag;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready when idle", {31'd0, req_ready}, 1);
    req_valid = 1'b1; req_byte = b;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R1 busy after accept", {31'd0, busy}, 1);
    wait_done();
    chk(short_flags === es, "R8 R9 short flags", {24'd0, short_flags}, {24'd0, es});
    chk(open_flags === eo, "R8 R10 open flags", {24'd0, open_flags}, {24'd0, eo});
    chk(((short_flags | open_flags) & ~(b ^ diag)) === 8'h00, "R11 agreeing bits clear",
        {24'd0, short_flags | open_flags}, {24'd0, b ^ diag});
    chk(busy === 1'b1, "R12 busy in done cycle", {31'd0, busy}, 1);
    chk(s_latch === b, "R2 driver latch", {24'd0, s_latch}, {24'd0, b});
    chk(fall_in_seq == 2, "R2 transfer count", fall_in_seq, 2);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && req_ready === 1'b1, "R12 R1 pulse end",
        {29'd0, done, busy, req_ready}, 32'h1);
    chk(bad_edge == 0 && bad_gate == 0, "R3 clock quiet at select edges", bad_edge + bad_gate, 0);
    chk(bad_lead == 0 && bad_lag == 0, "R4 lead and lag", bad_lead + bad_lag, 0);
    chk(bad_high == 0 && bad_low == 0, "R5 clock phases", bad_high + bad_low, 0);
    chk(bad_mosi == 0, "R6 data steady", bad_mosi, 0);
    chk(bad_settle == 0, "R7 settle gap", bad_settle, 0);
  endtask

  localparam logic [23:0] VEC [6] = '{
    {8'h00, 8'h00, 8'h00}, {8'hFF, 8'h00, 8'h00}, {8'h00, 8'hFF, 8'h00},
    {8'hFF, 8'h00, 8'hFF}, {8'hA5, 8'h0F, 8'hF0}, {8'h3C, 8'h81, 8'h18}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 R12 reset status",
        {29'd0, req_ready, busy, done}, 32'h4);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R3 reset bus idle", {30'd0, spi_cs_n, spi_sclk}, 32'h2);
    chk(short_flags === 8'h00 && open_flags === 8'h00, "R11 reset flags",
        {16'd0, short_flags, open_flags}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 6; i++) run_seq(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);

    // R11: flags hold after done
    begin
      logic [7:0] hs, ho;
      hs = short_flags; ho = open_flags;
      repeat (30) @(negedge clk);
      chk(short_flags === hs && open_flags === ho, "R11 flags hold", {24'd0, short_flags}, {24'd0, hs});
    end

    // R1: request offered while busy is not taken
    stuck_hi = 8'h00; floating = 8'h00;
    @(negedge clk);
    req_valid = 1'b1; req_byte = 8'h5A;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(req_ready === 1'b0, "R1 ready low while busy", {31'd0, req_ready}, 0);
    req_valid = 1'b1; req_byte = 8'h11;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    chk(s_latch === 8'h5A, "R1 busy request ignored", {24'd0, s_latch}, 32'h5A);
    chk(fall_in_seq == 2, "R1 no extra transfer", fall_in_seq, 2);
    chk(short_flags === 8'h00 && open_flags === 8'h00, "R11 healthy channels",
        {16'd0, short_flags, open_flags}, 0);
    repeat (60) @(negedge clk);
    chk(spi_cs_n === 1'b1 && busy === 1'b0, "R1 stays idle", {30'd0, spi_cs_n, busy}, 32'h2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule